// File: doc/BRIEF.md
# Asynchronous Character Receiver with Framing Check

This block takes one serial input that rests at logic 1 and turns each start/stop framed character on it into a parallel word. An oversampling divider produces OVS ticks per bit period from the system clock. A falling edge on the synchronised line marks a possible start bit. The block checks the line again half a bit later to confirm it. Each later bit is then sampled at the middle of its period, one full bit apart.

The character format is set by level inputs. The data field runs from 5 to 8 bits. A parity bit can be enabled, with even or odd sense, and one or two stop bits close the character. The format is captured when a start edge is accepted. For each character the block gives one valid pulse. The pulse carries the received data, a parity error flag and a framing error flag. Bit timing restarts at every start edge, so rate error does not carry from one character to the next.

Top module: `serial_char_rx`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and data_o reads 0 until a character has been received.
- R2: A start edge is a 1-to-0 change on the line after a two-flop synchroniser. The line is read again OVS/2 ticks later. If it reads 1, the event is a glitch and no valid_o pulse follows.
- R3: A tick occurs every CLK_DIV clocks and there are OVS ticks per bit. Each bit after the start bit is sampled OVS ticks after the previous sample. Characters sent up to about 1.5 % fast or slow are still received correctly.
- R4: data_len_i selects the data length as code plus 5 (0 gives 5 bits, 3 gives 8 bits). Bits arrive LSB first. data_o is right-aligned, and its bits at and above the data length are 0.
- R5: When par_en_i is 1, one parity bit follows the data. With par_odd_i at 0 the data plus parity must hold an even count of ones; with par_odd_i at 1 the count must be odd. A mismatch sets par_err_o with the valid pulse.
- R6: When par_en_i is 0, no parity bit is taken: the bit after the data is the first stop bit, and par_err_o is 0 with every valid pulse.
- R7: stop2_i at 0 gives one stop bit and at 1 gives two. frame_err_o is set with the valid pulse if any stop sample reads 0.
- R8: valid_o is a single-cycle pulse. It is raised one clock after the tick that samples the last stop bit, together with data_o, par_err_o and frame_err_o.
- R9: Timing realigns on each start edge. Characters sent back to back with no idle time are each received. After a framing error with the line still low, a new character is accepted only after the line has returned to 1 and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles at 1 |
| data_len_i | input | 2 | Data length code, length = code + 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop2_i | input | 1 | 1 selects two stop bits |
| data_o | output | 8 | Received data, right-aligned |
| valid_o | output | 1 | One-cycle pulse for each received character |
| par_err_o | output | 1 | Parity mismatch for this character |
| frame_err_o | output | 1 | A stop sample read 0 |

## Verification
The hardest cases to reach from the ports are the ones where the start-bit decision depends on timing inside the bit. The first is a short low pulse that must be rejected at the mid-start check. The second is a stop bit held low, after which the line must not be mistaken for a new start. The bench drives a 12-clock low glitch, well under half a bit, and then a real character. It also sends a low stop bit followed by a held 1 and then a clean character. Back-to-back characters at bit periods of 63 and 65 clocks, against a nominal 64, show that timing realigns on each start edge and that no error builds up across characters.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS = 8;
  localparam int BIT_IDX_W = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } rx_cfg_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (clr_i)         cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = !clr_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/srx_core.sv
module srx_core
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                fall_i,
  input  rx_cfg_t             cfg_i,
  output logic                clr_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                par_err_o,
  output logic                frame_err_o
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] OVS_MID  = OW'(OVS / 2 - 1);
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);

  rx_state_e             state_q;
  rx_cfg_t               cfg_q;
  logic [OW-1:0]         ovs_q;
  logic [BIT_IDX_W-1:0]  bit_q;
  logic [MAX_BITS-1:0]   shf_q;
  logic                  par_acc_q;
  logic                  stop_idx_q;
  logic                  ferr_acc_q;

  logic                  at_mid, at_sample, ferr_now;
  logic [BIT_IDX_W-1:0]  last_idx;

  assign clr_o     = fall_i && (state_q == ST_IDLE);
  assign at_mid    = tick_i && (ovs_q == OVS_MID);
  assign at_sample = tick_i && (ovs_q == OVS_LAST);
  assign last_idx  = {1'b1, cfg_q.len};
  assign ferr_now  = ferr_acc_q | ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cfg_q       <= '0;
      ovs_q       <= '0;
      bit_q       <= '0;
      shf_q       <= '0;
      par_acc_q   <= 1'b0;
      stop_idx_q  <= 1'b0;
      ferr_acc_q  <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && state_q != ST_IDLE) ovs_q <= ovs_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_q <= ST_START;
            cfg_q   <= cfg_i;
            ovs_q   <= '0;
          end
        end
        ST_START: begin
          if (at_mid) begin
            ovs_q <= '0;
            if (rx_i) begin
              state_q <= ST_IDLE;   // glitch
            end else begin
              state_q   <= ST_DATA;
              bit_q     <= '0;
              shf_q     <= '0;
              par_acc_q <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (at_sample) begin
            ovs_q        <= '0;
            shf_q[bit_q] <= rx_i;
            par_acc_q    <= par_acc_q ^ rx_i;
            if (bit_q == last_idx) begin
              state_q    <= cfg_q.par_en ? ST_PAR : ST_STOP;
              stop_idx_q <= 1'b0;
              ferr_acc_q <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (at_sample) begin
            ovs_q     <= '0;
            par_acc_q <= par_acc_q ^ rx_i;
            state_q   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (at_sample) begin
            ovs_q <= '0;
            if (cfg_q.stop2 && !stop_idx_q) begin
              stop_idx_q <= 1'b1;
              ferr_acc_q <= ferr_now;
            end else begin
              state_q     <= ST_IDLE;
              valid_o     <= 1'b1;
              data_o      <= shf_q;
              frame_err_o <= ferr_now;
              par_err_o   <= cfg_q.par_en & (par_acc_q ^ cfg_q.par_odd);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import srx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OVS     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic [1:0] data_len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       stop2_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       par_err_o,
  output logic       frame_err_o
);
  logic    rx_s, rx_prev_q, fall, baud_tick, baud_clr;
  rx_cfg_t cfg;

  srx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_prev_q <= 1'b1;
    else         rx_prev_q <= rx_s;
  end

  assign fall = rx_prev_q & ~rx_s;
  assign cfg  = '{len: data_len_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};

  srx_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (baud_clr),
    .tick_o(baud_tick)
  );

  srx_core #(.OVS(OVS)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (baud_tick),
    .rx_i       (rx_s),
    .fall_i     (fall),
    .cfg_i      (cfg),
    .clr_o      (baud_clr),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .par_err_o  (par_err_o),
    .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic [1:0] data_len_i,
  input logic       par_en_i,
  input logic       par_err_o,
  input logic       tick
);
  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!valid_o);
  end

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_after_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick));

  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_len_i == 2'd0) |-> (data_o[7:5] == 3'b000));

  assert_no_perr_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);
endmodule

bind serial_char_rx srx_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_o   (valid_o),
  .data_o    (data_o),
  .data_len_i(data_len_i),
  .par_en_i  (par_en_i),
  .par_err_o (par_err_o),
  .tick      (baud_tick)
);

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
  localparam int BT = 64;  // nominal bit period in clocks (CLK_DIV 4 x OVS 16)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] data_len = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic [7:0] data;
  logic       valid, par_err, frame_err;

  int total = 0, bad = 0, valid_seen = 0, valid_exp = 0;
  logic [7:0] q_data[$];
  bit         q_perr[$], q_ferr[$];
  string      q_tag[$];
  bit         prev_valid = 0;

  always #4 clk = ~clk;

  serial_char_rx #(.CLK_DIV(4), .OVS(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .data_len_i(data_len),
    .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .data_o(data), .valid_o(valid), .par_err_o(par_err), .frame_err_o(frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && prev_valid) chk(0, "R8", "valid wider than one cycle", 1, 0);
      if (valid) begin
        valid_seen++;
        if (q_data.size() == 0) begin
          chk(0, "R2", "unexpected valid", 1, 0);
        end else begin
          logic [7:0] ed; bit ep, ef; string tg;
          ed = q_data.pop_front(); ep = q_perr.pop_front();
          ef = q_ferr.pop_front(); tg = q_tag.pop_front();
          chk(data == ed, tg, "data", data, ed);
          chk(par_err == ep, tg, "par_err", par_err, ep);
          chk(frame_err == ef, tg, "frame_err", frame_err, ef);
        end
      end
      prev_valid = valid;
    end
  end

  task automatic drive(input logic v, input int n);
    rx <= v;
    repeat (n) @(posedge clk);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send(input logic [7:0] d, input int len, input bit pe, input bit po,
                      input bit s2, input bit bad_par, input int bad_stop,
                      input int bt, input string tag);
    logic [7:0] dm;
    logic pbit;
    dm = d & 8'((1 << len) - 1);
    pbit = po ? ~(^dm) : (^dm);
    if (bad_par) pbit = ~pbit;
    data_len <= 2'(len - 5);
    par_en <= pe; par_odd <= po; stop2 <= s2;
    q_data.push_back(dm);
    q_perr.push_back(pe && bad_par);
    q_ferr.push_back(bad_stop != 0);
    q_tag.push_back(tag);
    valid_exp++;
    drive(1'b0, bt);
    for (int i = 0; i < len; i++) drive(dm[i], bt);
    if (pe) drive(pbit, bt);
    drive(bad_stop == 1 ? 1'b0 : 1'b1, bt);
    if (s2) drive(bad_stop == 2 ? 1'b0 : 1'b1, bt);
    rx <= 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b0, "R1", "valid in reset", valid, 0);
    chk(data == 8'h00, "R1", "data in reset", data, 0);
    rst_n <= 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
    @(posedge clk);

    send(8'hA5, 8, 0, 0, 0, 0, 0, BT, "R4_8bit");
    drive(1'b1, BT);
    send(8'hFF, 5, 0, 0, 0, 0, 0, BT, "R4_5bit_upper_zero");
    drive(1'b1, BT);
    send(8'h2D, 6, 0, 0, 0, 0, 0, BT, "R4_6bit");
    send(8'h5A, 7, 0, 0, 0, 0, 0, BT, "R4_7bit");
    drive(1'b1, BT);
    send(8'h3C, 8, 1, 0, 0, 0, 0, BT, "R5_even_ok");
    send(8'h3D, 8, 1, 0, 0, 1, 0, BT, "R5_even_bad");
    send(8'h81, 7, 1, 1, 0, 0, 0, BT, "R5_odd_ok");
    send(8'h0E, 6, 1, 1, 1, 1, 0, BT, "R5_odd_bad");
    drive(1'b1, BT);
    send(8'hC3, 8, 0, 1, 0, 1, 0, BT, "R6_parity_off");
    send(8'h96, 8, 0, 0, 1, 0, 0, BT, "R7_two_stop_ok");
    drive(1'b1, BT);
    send(8'h11, 8, 0, 0, 0, 0, 1, BT, "R7_stop_low");
    drive(1'b1, BT);
    send(8'h22, 8, 1, 0, 1, 0, 2, BT, "R7_second_stop_low");
    drive(1'b1, BT);
    send(8'h7E, 8, 0, 0, 0, 0, 0, BT, "R9_after_frame_err");
    drive(1'b1, BT);

    // R2: short glitch must give no character
    drive(1'b0, 12);
    drive(1'b1, 4 * BT);
    @(negedge clk);
    chk(valid_seen == valid_exp, "R2", "valid count after glitch", valid_seen, valid_exp);
    @(posedge clk);
    send(8'h69, 8, 0, 0, 0, 0, 0, BT, "R2_after_glitch");

    // R3 R9: off-rate characters back to back, realigned on each start
    send(8'hB7, 8, 1, 1, 1, 0, 0, 63, "R3_fast");
    send(8'h4C, 8, 1, 1, 1, 0, 0, 63, "R9_fast_b2b");
    send(8'hE1, 8, 1, 0, 1, 0, 0, 65, "R3_slow");
    send(8'h1E, 8, 1, 0, 1, 0, 0, 65, "R9_slow_b2b");
    drive(1'b1, 2 * BT);

    @(negedge clk);
    chk(valid_seen == valid_exp, "R8", "total valid pulses", valid_seen, valid_exp);
    chk(q_data.size() == 0, "R8", "characters outstanding", q_data.size(), 0);
    finish_run();
  end
endmodule